// File: doc/BRIEF.md
# Memory Write Packet Framer

This block turns one memory write request into the complete byte stream that a link transmitter places on the wire. A request arrives on a command handshake with its address, addressing mode, length in doublewords, tag, requester identifier, first and last byte enables, traffic class, attributes and a flag that asks for an end-to-end CRC. The payload arrives one byte per transfer on a separate valid/ready input. The framed packet leaves one byte per transfer on a valid/ready output.

Each frame holds these fields in order: start framing, a two-byte sequence field, a 3-DW or 4-DW header, the payload, an optional 4-byte end-to-end CRC, a 4-byte link CRC, and, in the older format only, a closing end symbol. A per-request format select picks the 1-byte start plus end symbol form or the 4-byte start token form with no end symbol. The sequence number is kept inside the block and advances once per frame. The block accepts a new request only after the final byte of the current frame has left.

Top module: `tlp_mwr_framer`

## Requirements
- R1: After reset, out_valid and pl_ready are 0 and cmd_ready is 1. The first frame carries sequence number 0.
- R2: With req_gen3=0, the frame begins with one byte 0xFB and ends with one byte 0xFD. The 0xFD byte is the only byte flagged by out_last.
- R3: With req_gen3=1, the frame begins with the four bytes 0xF0, 0xAC, 0x53, 0x0F in that order and has no end symbol. The last link CRC byte is the byte flagged by out_last.
- R4: The two bytes after the start framing are {4'h0, seq[11:8]} and then seq[7:0]. seq starts at 0, rises by one per frame and wraps from 4095 to 0.
- R5: Header bytes 0 to 7 are {3'b01?,5'b00000} with bit 5 = req_addr64, then {1'b0, tc, 4'b0}, then {td, 1'b0, attr, 2'b00, len[9:8]}, then len[7:0], then requester ID high and low bytes, then tag, then {last_be, first_be}. td equals req_ecrc_en.
- R6: For 32-bit addressing the header is 12 bytes and bytes 8 to 11 are {addr[31:2],2'b00}, sent most significant byte first. For 64-bit addressing the header is 16 bytes, with addr[63:32] in bytes 8 to 11 followed by {addr[31:2],2'b00}.
- R7: Exactly len*4 payload bytes pass from pl_data to out_data unchanged, with len=0 meaning 4096 bytes. pl_ready is 0 outside that window.
- R8: When req_ecrc_en=1, four end-to-end CRC bytes follow the payload. When it is 0, they are absent. The CRC covers header and payload.
- R9: Four link CRC bytes always follow. They cover the sequence field, header, payload and end-to-end CRC. Both CRCs use polynomial 0x04C11DB7 with seed 0xFFFFFFFF, process each byte most significant bit first, invert the result, and are sent most significant byte first.
- R10: cmd_ready is 0 from the cycle after a request is accepted until the final byte of its frame has been transferred. No byte is produced without an accepted request.
- R11: While out_valid is 1 and out_ready is 0 outside the payload section, out_valid stays 1 and out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Framer idle, request taken on this cycle |
| req_gen3 | input | 1 | 1 selects the 4-byte start token format |
| req_addr64 | input | 1 | 1 selects the 4-DW header with 64-bit address |
| req_addr | input | 64 | Target byte address |
| req_len | input | 10 | Payload length in doublewords, 0 means 1024 |
| req_tag | input | 8 | Transaction tag |
| req_rid | input | 16 | Requester identifier |
| req_first_be | input | 4 | First doubleword byte enables |
| req_last_be | input | 4 | Last doubleword byte enables |
| req_tc | input | 3 | Traffic class |
| req_attr | input | 2 | Attribute bits |
| req_ecrc_en | input | 1 | Append end-to-end CRC, sets TD |
| pl_valid | input | 1 | Payload byte present |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
Requests are tried in every pairing of format select and addressing mode, with and without the end-to-end CRC, so that a wrong header length, a missing or extra CRC field or a misplaced end symbol all show up as a byte mismatch. A full-size request with length field 0 separates the 1024-doubleword case from a zero-length one. Random stalls on both the output sink and the payload source tell true holding apart from bytes that are dropped or repeated. A run of several thousand short frames moves the sequence number across its 4095-to-0 wrap.

// File: rtl/tlpf_pkg.sv
package tlpf_pkg;

    localparam int SEQ_W   = 12;
    localparam int LEN_W   = 10;
    localparam int ADDR_W  = 64;
    localparam int PCNT_W  = LEN_W + 3;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_SEQ,
        PH_HDR,
        PH_PAY,
        PH_ECRC,
        PH_LCRC,
        PH_END
    } phase_t;

    typedef struct packed {
        logic              gen3;
        logic              a64;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [7:0]        tag;
        logic [15:0]       rid;
        logic [3:0]        first_be;
        logic [3:0]        last_be;
        logic [2:0]        tc;
        logic [1:0]        attr;
        logic              td;
    } req_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
        logic [31:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[31] ^ d[i]) c = (c << 1) ^ CRC_POLY;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [PCNT_W-1:0] payload_bytes(input logic [LEN_W-1:0] len);
        if (len == '0) return PCNT_W'(1 << (LEN_W + 2));
        return {1'b0, len, 2'b00};
    endfunction

endpackage

// File: rtl/tlpf_hdr_build.sv
module tlpf_hdr_build
    import tlpf_pkg::*;
(
    input  req_t       req,
    input  logic [3:0] idx,
    output logic [7:0] hdr_byte,
    output logic [4:0] hdr_len
);
    logic [31:0]  dw0, dw1, dw2, dw3;
    logic [127:0] hdr;
    logic [31:0]  lo_addr;

    always_comb begin
        lo_addr = {req.addr[31:2], 2'b00};
        dw0 = {2'b01, req.a64, 5'b00000,
               1'b0, req.tc, 4'b0000,
               req.td, 1'b0, req.attr, 2'b00, req.len[9:8],
               req.len[7:0]};
        dw1 = {req.rid, req.tag, req.last_be, req.first_be};
        dw2 = req.a64 ? req.addr[63:32] : lo_addr;
        dw3 = lo_addr;
        hdr = {dw0, dw1, dw2, dw3};
        hdr_byte = hdr[8*(15 - idx) +: 8];
        hdr_len  = req.a64 ? 5'd16 : 5'd12;
    end
endmodule

// File: rtl/tlpf_crc32.sv
module tlpf_crc32
    import tlpf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_fin
);
    logic [31:0] state_q;

    always_ff @(posedge clk) begin
        if (rst || clr)  state_q <= CRC_SEED;
        else if (en)     state_q <= crc32_step(state_q, din);
    end

    assign crc_fin = ~state_q;
endmodule

// File: rtl/tlpf_seq_ctr.sv
module tlpf_seq_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] seq
);
    always_ff @(posedge clk) begin
        if (rst)      seq <= '0;
        else if (inc) seq <= seq + 1'b1;
    end
endmodule

// File: rtl/tlp_mwr_framer.sv
module tlp_mwr_framer
    import tlpf_pkg::*;
#(
    parameter logic [7:0]  START_SYM = 8'hFB,
    parameter logic [7:0]  END_SYM   = 8'hFD,
    parameter logic [31:0] G3_START  = 32'hF0AC_530F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              req_gen3,
    input  logic              req_addr64,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        req_tag,
    input  logic [15:0]       req_rid,
    input  logic [3:0]        req_first_be,
    input  logic [3:0]        req_last_be,
    input  logic [2:0]        req_tc,
    input  logic [1:0]        req_attr,
    input  logic              req_ecrc_en,
    input  logic              pl_valid,
    output logic              pl_ready,
    input  logic [7:0]        pl_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last
);
    localparam int SEQ_FIELD_W = 16;

    phase_t            ph;
    logic [PCNT_W-1:0] idx;
    logic [PCNT_W-1:0] last_idx;
    req_t              rq;
    logic              fire, cmd_fire, ph_last;
    logic [7:0]        hdr_byte;
    logic [4:0]        hdr_len;
    logic [31:0]       ecrc_fin, lcrc_fin;
    logic [SEQ_W-1:0]  seq_q;
    logic [SEQ_FIELD_W-1:0] seq_field;
    logic              lcrc_en, ecrc_en, seq_inc;
    phase_t            ph_next;

    assign cmd_ready = (ph == PH_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;
    assign out_valid = (ph != PH_IDLE) && ((ph != PH_PAY) || pl_valid);
    assign pl_ready  = (ph == PH_PAY) && out_ready;
    assign fire      = out_valid && out_ready;
    assign seq_field = SEQ_FIELD_W'(seq_q);

    tlpf_hdr_build u_hdr (
        .req      (rq),
        .idx      (idx[3:0]),
        .hdr_byte (hdr_byte),
        .hdr_len  (hdr_len)
    );

    assign ecrc_en = fire && ((ph == PH_HDR) || (ph == PH_PAY));
    assign lcrc_en = fire && ((ph == PH_SEQ) || (ph == PH_HDR) ||
                              (ph == PH_PAY) || (ph == PH_ECRC));

    tlpf_crc32 u_ecrc (
        .clk (clk), .rst (rst), .clr (cmd_fire), .en (ecrc_en),
        .din (out_data), .crc_fin (ecrc_fin)
    );

    tlpf_crc32 u_lcrc (
        .clk (clk), .rst (rst), .clr (cmd_fire), .en (lcrc_en),
        .din (out_data), .crc_fin (lcrc_fin)
    );

    assign seq_inc = fire && out_last;

    tlpf_seq_ctr #(.W(SEQ_W)) u_seq (
        .clk (clk), .rst (rst), .inc (seq_inc), .seq (seq_q)
    );

    always_comb begin
        last_idx = '0;
        ph_next  = PH_IDLE;
        case (ph)
            PH_START: begin
                last_idx = rq.gen3 ? PCNT_W'(3) : '0;
                ph_next  = PH_SEQ;
            end
            PH_SEQ: begin
                last_idx = PCNT_W'(1);
                ph_next  = PH_HDR;
            end
            PH_HDR: begin
                last_idx = PCNT_W'(hdr_len) - 1'b1;
                ph_next  = PH_PAY;
            end
            PH_PAY: begin
                last_idx = payload_bytes(rq.len) - 1'b1;
                ph_next  = rq.td ? PH_ECRC : PH_LCRC;
            end
            PH_ECRC: begin
                last_idx = PCNT_W'(3);
                ph_next  = PH_LCRC;
            end
            PH_LCRC: begin
                last_idx = PCNT_W'(3);
                ph_next  = rq.gen3 ? PH_IDLE : PH_END;
            end
            PH_END: begin
                last_idx = '0;
                ph_next  = PH_IDLE;
            end
            default: begin
                last_idx = '0;
                ph_next  = PH_IDLE;
            end
        endcase
    end

    assign ph_last  = (idx == last_idx);
    assign out_last = (ph == PH_END) || ((ph == PH_LCRC) && ph_last && rq.gen3);

    always_comb begin
        case (ph)
            PH_START: out_data = rq.gen3 ? G3_START[8*(3 - idx[1:0]) +: 8] : START_SYM;
            PH_SEQ:   out_data = seq_field[8*(1 - idx[0]) +: 8];
            PH_HDR:   out_data = hdr_byte;
            PH_PAY:   out_data = pl_data;
            PH_ECRC:  out_data = ecrc_fin[8*(3 - idx[1:0]) +: 8];
            PH_LCRC:  out_data = lcrc_fin[8*(3 - idx[1:0]) +: 8];
            PH_END:   out_data = END_SYM;
            default:  out_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            idx <= '0;
            rq  <= '0;
        end else if (cmd_fire) begin
            ph  <= PH_START;
            idx <= '0;
            rq.gen3     <= req_gen3;
            rq.a64      <= req_addr64;
            rq.addr     <= req_addr;
            rq.len      <= req_len;
            rq.tag      <= req_tag;
            rq.rid      <= req_rid;
            rq.first_be <= req_first_be;
            rq.last_be  <= req_last_be;
            rq.tc       <= req_tc;
            rq.attr     <= req_attr;
            rq.td       <= req_ecrc_en;
        end else if (fire) begin
            if (ph_last) begin
                ph  <= ph_next;
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (out_valid && !cmd_ready)); // R10

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && ph != PH_PAY) |=> (out_valid && $stable(out_data))); // R11

    AST_NO_PAY_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_PAY) |-> (idx < payload_bytes(rq.len))); // R7

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (seq_q == SEQ_W'($past(seq_q) + 1'b1))); // R4

    AST_G3_NO_END: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_END) |-> !rq.gen3); // R3

    AST_ECRC_ONLY_TD: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ECRC) |-> rq.td); // R8

    AST_PL_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        pl_ready |-> (out_ready && !cmd_ready)); // R7
endmodule

// File: tb/tlp_mwr_framer_tb.sv
module tlp_mwr_framer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;
    localparam logic [7:0]  T_START = 8'hFB;
    localparam logic [7:0]  T_END   = 8'hFD;
    localparam logic [31:0] T_G3    = 32'hF0AC_530F;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic        req_gen3 = 0, req_addr64 = 0;
    logic [63:0] req_addr = '0;
    logic [9:0]  req_len = '0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_rid = '0;
    logic [3:0]  req_first_be = '0, req_last_be = '0;
    logic [2:0]  req_tc = '0;
    logic [1:0]  req_attr = '0;
    logic        req_ecrc_en = 0;
    logic        pl_valid = 0;
    logic        pl_ready;
    logic [7:0]  pl_data = '0;
    logic        out_valid;
    logic        out_ready = 1;
    logic [7:0]  out_data;
    logic        out_last;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit stall = 0;
    bit busy = 0;
    int exp_seq = 0;

    logic [7:0] exp_d[$];
    logic       exp_l[$];
    string      exp_r[$];
    logic [7:0] pay_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tlp_mwr_framer u_dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .req_gen3(req_gen3), .req_addr64(req_addr64), .req_addr(req_addr),
        .req_len(req_len), .req_tag(req_tag), .req_rid(req_rid),
        .req_first_be(req_first_be), .req_last_be(req_last_be),
        .req_tc(req_tc), .req_attr(req_attr), .req_ecrc_en(req_ecrc_en),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [31:0] bcrc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic top;
            top = r[31] ^ b[7-k];
            r = {r[30:0], 1'b0};
            if (top) r = r ^ 32'h04C1_1DB7;
        end
        return r;
    endfunction

    task automatic push_exp(input logic [7:0] d, input logic l, input string r);
        exp_d.push_back(d);
        exp_l.push_back(l);
        exp_r.push_back(r);
    endtask

    // Driver: issues one request, then queues its payload and expected bytes
    task automatic send(input bit g3, input bit a64, input logic [63:0] addr,
                        input logic [9:0] len, input logic [7:0] tag,
                        input logic [15:0] rid, input logic [3:0] fbe,
                        input logic [3:0] lbe, input logic [2:0] tc,
                        input logic [1:0] attr, input bit td);
        logic [7:0]  hb[$];
        logic [31:0] lc, ec, fin;
        int nb;
        @(posedge clk); #1;
        req_gen3 = g3; req_addr64 = a64; req_addr = addr; req_len = len;
        req_tag = tag; req_rid = rid; req_first_be = fbe; req_last_be = lbe;
        req_tc = tc; req_attr = attr; req_ecrc_en = td;
        cmd_valid = 1;
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        @(posedge clk); #1;
        cmd_valid = 0;
        busy = 1;
        nb = (len == 0) ? 4096 : int'(len) * 4;
        lc = 32'hFFFF_FFFF;
        ec = 32'hFFFF_FFFF;
        if (g3) for (int i = 0; i < 4; i++) push_exp(T_G3[31-8*i -: 8], 0, "R3");
        else    push_exp(T_START, 0, "R2");
        push_exp({4'h0, 4'(exp_seq >> 8)}, 0, "R4");
        push_exp(8'(exp_seq), 0, "R4");
        lc = bcrc(lc, {4'h0, 4'(exp_seq >> 8)});
        lc = bcrc(lc, 8'(exp_seq));
        hb.push_back({2'b01, a64, 5'b0});
        hb.push_back({1'b0, tc, 4'b0});
        hb.push_back({td, 1'b0, attr, 2'b00, len[9:8]});
        hb.push_back(len[7:0]);
        hb.push_back(rid[15:8]);
        hb.push_back(rid[7:0]);
        hb.push_back(tag);
        hb.push_back({lbe, fbe});
        if (a64) for (int i = 0; i < 4; i++) hb.push_back(addr[63-8*i -: 8]);
        hb.push_back(addr[31:24]);
        hb.push_back(addr[23:16]);
        hb.push_back(addr[15:8]);
        hb.push_back({addr[7:2], 2'b00});
        for (int i = 0; i < hb.size(); i++) begin
            push_exp(hb[i], 0, (i < 8) ? "R5" : "R6");
            lc = bcrc(lc, hb[i]);
            ec = bcrc(ec, hb[i]);
        end
        for (int i = 0; i < nb; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            pay_q.push_back(b);
            push_exp(b, 0, "R7");
            lc = bcrc(lc, b);
            ec = bcrc(ec, b);
        end
        if (td) begin
            fin = ~ec;
            for (int i = 0; i < 4; i++) begin
                push_exp(fin[31-8*i -: 8], 0, "R8");
                lc = bcrc(lc, fin[31-8*i -: 8]);
            end
        end
        fin = ~lc;
        for (int i = 0; i < 4; i++) push_exp(fin[31-8*i -: 8], g3 && (i == 3), "R9");
        if (!g3) push_exp(T_END, 1, "R2");
        exp_seq = (exp_seq + 1) % 4096;
    endtask

    // Payload source
    initial begin
        forever begin
            bit hs;
            @(negedge clk);
            hs = pl_valid && pl_ready;
            @(posedge clk); #1;
            if (hs && pay_q.size() > 0) void'(pay_q.pop_front());
            pl_valid = (pay_q.size() > 0) && (!stall || ($urandom % 3 != 0));
            pl_data  = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
            out_ready = !stall || ($urandom % 4 != 0);
        end
    end

    // Monitor / scoreboard
    initial begin
        bit         prev_stall = 0;
        logic [7:0] prev_data = '0;
        string      prev_req = "";
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall && prev_req != "R7")
                    check(out_valid && out_data == prev_data, "R11", "held byte",
                          {23'b0, out_valid, out_data}, {23'b0, 1'b1, prev_data});
                if (busy && cmd_ready)
                    check(0, "R10", "cmd_ready during frame", 1, 0);
                if (pay_q.size() == 0 && pl_ready)
                    check(0, "R7", "pl_ready after payload", 1, 0);
                prev_stall = 0;
                if (out_valid) begin
                    if (exp_d.size() == 0) begin
                        check(0, "R10", "byte with no request", out_data, 0);
                    end else if (out_ready) begin
                        logic [7:0] d;
                        logic       l;
                        string      r;
                        d = exp_d.pop_front();
                        l = exp_l.pop_front();
                        r = exp_r.pop_front();
                        check(out_data == d, r, "data", out_data, d);
                        check(out_last == l, r, "last flag", out_last, l);
                        if (out_last) busy = 0;
                    end else begin
                        prev_stall = 1;
                        prev_data  = out_data;
                        prev_req   = exp_r[0];
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                check(0, "R10", "watchdog expired", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        check(pl_ready == 0, "R1", "pl_ready after reset", pl_ready, 0);
        check(cmd_ready == 1, "R1", "cmd_ready after reset", cmd_ready, 1);

        // first frame checks sequence 0 (R1) through the scoreboard
        send(0, 0, 64'h0000_0000_1234_567B, 10'd1, 8'h11, 16'hBEEF, 4'hF, 4'h0, 3'd2, 2'd1, 0);
        send(0, 1, 64'hDEAD_BEEF_CAFE_0004, 10'd3, 8'h22, 16'h0102, 4'hE, 4'h7, 3'd7, 2'd3, 1);
        send(1, 0, 64'h0000_0000_8000_0010, 10'd2, 8'h33, 16'hA5A5, 4'h3, 4'hC, 3'd0, 2'd2, 1);
        stall = 1;
        send(1, 1, 64'h0123_4567_89AB_CDEF, 10'd5, 8'h44, 16'h5A5A, 4'h1, 4'h8, 3'd5, 2'd0, 0);
        send(0, 0, 64'h0000_0000_0000_1000, 10'd0, 8'h55, 16'h00FF, 4'hF, 4'hF, 3'd1, 2'd1, 1);
        send(1, 1, 64'hFFFF_0000_0000_FFFC, 10'd0, 8'h66, 16'h7777, 4'hF, 4'hF, 3'd3, 2'd2, 0);
        stall = 0;
        // Filler frames to carry the sequence number across its wrap (R4)
        for (int i = 6; i < 4098; i++) begin
            send(i[0], 0, 64'(i * 4), 10'd1, 8'(i), 16'(i), 4'hF, 4'h0, 3'(i), 2'(i), 0);
        end
        while (exp_d.size() > 0) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(cmd_ready == 1 && out_valid == 0, "R10", "idle after last frame",
              {cmd_ready, out_valid}, 2'b10);
        finish_run();
    end
endmodule